// File: doc/BRIEF.md
# Multithreaded Pipeline Stage Controller

This block is the control for one stage of an in-order pipeline that interleaves several hardware threads. Instruction tokens arrive from the upstream stage, one per cycle. Each token is a thread number and a sequence number, plus a flag that marks it as already cancelled. The block holds accepted tokens in a small skid store that all threads share. It forwards at most one token per cycle to the downstream stage when that stage reports free room.

Each thread has its own status machine. A thread stalls when the stage just after it blocks that thread, or when a resource stall is pending for it. On entry into the stalled state the block raises a one-cycle block flag toward the upstream stage. It raises a one-cycle unblock flag once the thread has drained its held tokens. A squash request names a thread and a sequence number. It cuts every held token of that thread that is younger than the number, and it also stops a younger token of that thread arriving in the same cycle. Two free-running counters split cycles into busy ones (a token was forwarded) and idle ones.

Top module: `mtps_stage_ctl`

## Requirements
- R1: A synchronous active-high reset puts every thread in Idle, empties the skid store, clears both cycle counters, and drives `out_vld`, `up_block` and `up_unblock` low.
- R2: Status codes on `thr_status` (3 bits per thread, thread t at bits 3t+2..3t) are Idle=0, Running=1, Blocked=2, Unblocking=3 and Squashing=4. An Idle thread becomes Running in the cycle after one of its tokens is accepted.
- R3: A thread is stalled when `dn_block[t]` or `res_stall[t]` is high. A stalled thread is Blocked in the next cycle and is never forwarded. `up_block[t]` is high for exactly one cycle, together with the Blocked status, when the thread enters Blocked through a stall from any other status. No pulse is given while the thread stays Blocked.
- R4: A Blocked thread whose stall has cleared goes to Unblocking. An Unblocking thread returns to Running, with a one-cycle `up_unblock[t]` pulse, in the cycle after its held tokens reach zero with no new token of its own arriving.
- R5: A squash (`sq_vld`, thread `sq_tid`, number S) removes every held token of that thread whose sequence number is greater than S and keeps those at or below S. A token of that thread arriving in the same cycle with a number greater than S is not stored. Tokens of one thread arrive in ascending sequence order.
- R6: A squashed thread shows Squashing in the next cycle, unless it is also stalled, in which case the stall wins. From Squashing it goes to Unblocking if it still holds tokens, else to Running. It forwards nothing in the squash cycle or in the Squashing cycle.
- R7: The total number of held tokens over all threads never exceeds WIDTH. A token arriving while WIDTH tokens are held is not stored.
- R8: A token arriving with `in_dead` high is never stored.
- R9: Each cycle in which `dn_free` is at least one, the block forwards the oldest held token of the lowest-numbered thread that holds tokens, is not stalled, is not being squashed, and is Idle, Running or Unblocking. The token appears on `out_vld`/`out_tid`/`out_seq` in the next cycle, and tokens of each thread leave in arrival order.
- R10: A thread eligible under R9 that holds tokens while `dn_free` is zero goes to Blocked without an `up_block` pulse.
- R11: `run_cycles` counts cycles in which a token was forwarded and `idle_cycles` counts all other cycles after reset. Both are visible one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Incoming token present |
| in_tid | input | TID_W | Thread of incoming token |
| in_seq | input | SEQ_W | Sequence number of incoming token |
| in_dead | input | 1 | Incoming token already cancelled |
| sq_vld | input | 1 | Squash request present |
| sq_tid | input | TID_W | Thread to squash |
| sq_seq | input | SEQ_W | Youngest sequence number to keep |
| dn_block | input | NTHREADS | Per-thread block from the next stage |
| res_stall | input | NTHREADS | Per-thread pending resource stall |
| dn_free | input | OCC_W | Free slots in the next stage |
| out_vld | output | 1 | Forwarded token present |
| out_tid | output | TID_W | Thread of forwarded token |
| out_seq | output | SEQ_W | Sequence number of forwarded token |
| up_block | output | NTHREADS | One-cycle block flag to the previous stage |
| up_unblock | output | NTHREADS | One-cycle unblock flag to the previous stage |
| thr_status | output | 3*NTHREADS | Per-thread status codes |
| run_cycles | output | CNT_W | Busy-cycle count |
| idle_cycles | output | CNT_W | Idle-cycle count |

## Verification
A squash and the arrival of a new token of the same thread can fall in the same cycle. The block must then truncate the held tokens and decide on the incoming one against the same number S. A stall can also land on the squash cycle and must win the status. Both cases are provoked on purpose, with a younger token arriving under a squash and a downstream block raised during a squash, and again many times by random traffic. They are judged by comparing every forwarded token, status and flag against a queue-based model of the requirements, cycle by cycle.

// File: rtl/mtps_pkg.sv
package mtps_pkg;

  typedef enum logic [2:0] {
    TS_IDLE = 3'd0,
    TS_RUN  = 3'd1,
    TS_BLK  = 3'd2,
    TS_UNB  = 3'd3,
    TS_SQ   = 3'd4
  } thr_state_e;

  typedef struct packed {
    thr_state_e st;
    logic       blk;
    logic       unblk;
  } thr_step_t;

  // Statuses in which a thread may hand a token downstream.
  function automatic logic may_issue(thr_state_e s);
    return (s == TS_IDLE) || (s == TS_RUN) || (s == TS_UNB);
  endfunction

  // One cycle of the per-thread status machine.
  function automatic thr_step_t thr_next(
    thr_state_e cur,
    logic       stall,
    logic       cut,
    logic       has_ent,
    logic       room,
    logic       drains,
    logic       ins
  );
    thr_step_t r;
    r.st    = cur;
    r.blk   = 1'b0;
    r.unblk = 1'b0;
    if (stall) begin
      r.st  = TS_BLK;
      r.blk = (cur != TS_BLK);
    end else if (cut) begin
      r.st = TS_SQ;
    end else if (cur == TS_BLK) begin
      r.st = TS_UNB;
    end else if (cur == TS_SQ) begin
      r.st = has_ent ? TS_UNB : TS_RUN;
    end else if (has_ent && !room) begin
      r.st = TS_BLK;
    end else if (cur == TS_UNB) begin
      if (drains && !ins) begin
        r.st    = TS_RUN;
        r.unblk = 1'b1;
      end
    end else if (cur == TS_IDLE && ins) begin
      r.st = TS_RUN;
    end
    return r;
  endfunction

endpackage

// File: rtl/mtps_skid_q.sv
module mtps_skid_q #(
  parameter int DEPTH = 4,
  parameter int SEQ_W = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [SEQ_W-1:0] push_seq,
  input  logic             pop,
  input  logic             cut,
  input  logic [SEQ_W-1:0] cut_seq,
  output logic [SEQ_W-1:0] head_seq,
  output logic [CW-1:0]    count
);

  logic [SEQ_W-1:0] mem_q [DEPTH];
  logic [SEQ_W-1:0] mem_d [DEPTH];
  logic [CW-1:0]    cnt_q, cnt_d, kept;

  // Entries are held oldest first, so survivors of a cut form a prefix.
  always_comb begin
    kept = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (CW'(i) < cnt_q && mem_q[i] <= cut_seq) kept = kept + CW'(1);
    end
  end

  always_comb begin
    mem_d = mem_q;
    cnt_d = cnt_q;
    if (cut) begin
      cnt_d = kept;
    end else if (pop && cnt_q != '0) begin
      for (int i = 0; i < DEPTH - 1; i++) mem_d[i] = mem_q[i+1];
      cnt_d = cnt_q - CW'(1);
    end
    if (push && cnt_d < CW'(DEPTH)) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (CW'(i) == cnt_d) mem_d[i] = push_seq;
      end
      cnt_d = cnt_d + CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      cnt_q <= cnt_d;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= mem_d[i];
    end
  end

  assign head_seq = mem_q[0];
  assign count    = cnt_q;

endmodule

// File: rtl/mtps_thr_ctl.sv
module mtps_thr_ctl
  import mtps_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       stall,
  input  logic       cut,
  input  logic       has_ent,
  input  logic       room,
  input  logic       drains,
  input  logic       ins,
  output thr_state_e st,
  output logic       can_issue,
  output logic       blk_pulse,
  output logic       unblk_pulse
);

  thr_step_t step;

  assign can_issue = !stall && !cut && may_issue(st);
  assign step      = thr_next(st, stall, cut, has_ent, room, drains, ins);

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= TS_IDLE;
      blk_pulse   <= 1'b0;
      unblk_pulse <= 1'b0;
    end else begin
      st          <= step.st;
      blk_pulse   <= step.blk;
      unblk_pulse <= step.unblk;
    end
  end

endmodule

// File: rtl/mtps_fwd_pick.sv
module mtps_fwd_pick #(
  parameter int N = 2
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt,
  output logic         any
);

  // Fixed ascending priority: lowest thread number wins.
  always_comb begin
    gnt = '0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && gnt == '0) gnt[i] = 1'b1;
    end
  end

  assign any = |req;

endmodule

// File: rtl/mtps_stage_ctl.sv
module mtps_stage_ctl
  import mtps_pkg::*;
#(
  parameter int NTHREADS = 2,
  parameter int WIDTH    = 4,
  parameter int SEQ_W    = 16,
  parameter int CNT_W    = 32,
  localparam int TID_W   = (NTHREADS > 1) ? $clog2(NTHREADS) : 1,
  localparam int OCC_W   = $clog2(WIDTH + 1)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  in_vld,
  input  logic [TID_W-1:0]      in_tid,
  input  logic [SEQ_W-1:0]      in_seq,
  input  logic                  in_dead,
  input  logic                  sq_vld,
  input  logic [TID_W-1:0]      sq_tid,
  input  logic [SEQ_W-1:0]      sq_seq,
  input  logic [NTHREADS-1:0]   dn_block,
  input  logic [NTHREADS-1:0]   res_stall,
  input  logic [OCC_W-1:0]      dn_free,
  output logic                  out_vld,
  output logic [TID_W-1:0]      out_tid,
  output logic [SEQ_W-1:0]      out_seq,
  output logic [NTHREADS-1:0]   up_block,
  output logic [NTHREADS-1:0]   up_unblock,
  output logic [3*NTHREADS-1:0] thr_status,
  output logic [CNT_W-1:0]      run_cycles,
  output logic [CNT_W-1:0]      idle_cycles
);

  localparam int SUM_W = $clog2(WIDTH * NTHREADS + 1);

  // Named internal events, visible to the bound checker.
  logic [NTHREADS-1:0] thr_stall, thr_cut, thr_ins, thr_req, fwd_gnt, thr_issue;
  logic [SUM_W-1:0]    occ_total;
  logic                in_take, in_cut, fwd_any, room;
  logic [TID_W-1:0]    gnt_tid;
  logic [SEQ_W-1:0]    gnt_seq;

  logic [OCC_W-1:0]    q_cnt  [NTHREADS];
  logic [SEQ_W-1:0]    q_head [NTHREADS];
  thr_state_e          q_st   [NTHREADS];

  assign room   = (dn_free != '0);
  assign in_cut = sq_vld && (sq_tid == in_tid) && (in_seq > sq_seq);

  always_comb begin
    occ_total = '0;
    for (int t = 0; t < NTHREADS; t++) occ_total = occ_total + SUM_W'(q_cnt[t]);
  end

  assign in_take = in_vld && !in_dead && !in_cut && (occ_total < SUM_W'(WIDTH));

  for (genvar t = 0; t < NTHREADS; t++) begin : g_thr
    assign thr_stall[t] = dn_block[t] | res_stall[t];
    assign thr_cut[t]   = sq_vld && (sq_tid == TID_W'(t));
    assign thr_ins[t]   = in_take && (in_tid == TID_W'(t));
    assign thr_req[t]   = thr_issue[t] && (q_cnt[t] != '0) && room;

    mtps_skid_q #(.DEPTH(WIDTH), .SEQ_W(SEQ_W)) u_q (
      .clk      (clk),
      .rst      (rst),
      .push     (thr_ins[t]),
      .push_seq (in_seq),
      .pop      (fwd_gnt[t]),
      .cut      (thr_cut[t]),
      .cut_seq  (sq_seq),
      .head_seq (q_head[t]),
      .count    (q_cnt[t])
    );

    mtps_thr_ctl u_ctl (
      .clk         (clk),
      .rst         (rst),
      .stall       (thr_stall[t]),
      .cut         (thr_cut[t]),
      .has_ent     (q_cnt[t] != '0),
      .room        (room),
      .drains      ((q_cnt[t] == '0) || (q_cnt[t] == OCC_W'(1) && fwd_gnt[t])),
      .ins         (thr_ins[t]),
      .st          (q_st[t]),
      .can_issue   (thr_issue[t]),
      .blk_pulse   (up_block[t]),
      .unblk_pulse (up_unblock[t])
    );

    assign thr_status[3*t +: 3] = q_st[t];
  end

  mtps_fwd_pick #(.N(NTHREADS)) u_pick (
    .req (thr_req),
    .gnt (fwd_gnt),
    .any (fwd_any)
  );

  always_comb begin
    gnt_tid = '0;
    gnt_seq = '0;
    for (int t = 0; t < NTHREADS; t++) begin
      if (fwd_gnt[t]) begin
        gnt_tid = TID_W'(t);
        gnt_seq = q_head[t];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld     <= 1'b0;
      out_tid     <= '0;
      out_seq     <= '0;
      run_cycles  <= '0;
      idle_cycles <= '0;
    end else begin
      out_vld <= fwd_any;
      if (fwd_any) begin
        out_tid    <= gnt_tid;
        out_seq    <= gnt_seq;
        run_cycles <= run_cycles + CNT_W'(1);
      end else begin
        idle_cycles <= idle_cycles + CNT_W'(1);
      end
    end
  end

endmodule

// File: rtl/mtps_stage_chk.sv
module mtps_stage_chk #(
  parameter int NTHREADS = 2,
  parameter int WIDTH    = 4,
  parameter int CNT_W    = 32,
  localparam int TID_W   = (NTHREADS > 1) ? $clog2(NTHREADS) : 1,
  localparam int OCC_W   = $clog2(WIDTH + 1),
  localparam int SUM_W   = $clog2(WIDTH * NTHREADS + 1)
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  sq_vld,
  input logic [TID_W-1:0]      sq_tid,
  input logic [NTHREADS-1:0]   dn_block,
  input logic [NTHREADS-1:0]   res_stall,
  input logic [OCC_W-1:0]      dn_free,
  input logic                  out_vld,
  input logic [TID_W-1:0]      out_tid,
  input logic [NTHREADS-1:0]   up_block,
  input logic [NTHREADS-1:0]   up_unblock,
  input logic [3*NTHREADS-1:0] thr_status,
  input logic [CNT_W-1:0]      run_cycles,
  input logic [CNT_W-1:0]      idle_cycles,
  input logic [SUM_W-1:0]      occ_total
);

  logic live_q;
  always_ff @(posedge clk) live_q <= !rst;

  assert_occ_bound_R7: assert property (@(posedge clk) disable iff (rst)
    occ_total <= SUM_W'(WIDTH));

  assert_no_room_R9: assert property (@(posedge clk) disable iff (rst)
    dn_free == '0 |=> !out_vld);

  assert_run_count_R11: assert property (@(posedge clk) disable iff (rst)
    (live_q && out_vld) |-> run_cycles == $past(run_cycles) + CNT_W'(1));

  assert_idle_count_R11: assert property (@(posedge clk) disable iff (rst)
    (live_q && !out_vld) |-> idle_cycles == $past(idle_cycles) + CNT_W'(1));

  for (genvar t = 0; t < NTHREADS; t++) begin : g_t
    assert_stall_quiet_R3: assert property (@(posedge clk) disable iff (rst)
      (dn_block[t] || res_stall[t]) |=> !(out_vld && out_tid == TID_W'(t)));

    assert_block_pulse_R3: assert property (@(posedge clk) disable iff (rst)
      ((dn_block[t] || res_stall[t]) && thr_status[3*t +: 3] != 3'd2) |=> up_block[t]);

    assert_block_state_R3: assert property (@(posedge clk) disable iff (rst)
      up_block[t] |-> thr_status[3*t +: 3] == 3'd2);

    assert_unblock_state_R4: assert property (@(posedge clk) disable iff (rst)
      up_unblock[t] |-> thr_status[3*t +: 3] == 3'd1);

    assert_squash_quiet_R6: assert property (@(posedge clk) disable iff (rst)
      (sq_vld && sq_tid == TID_W'(t)) |=> !(out_vld && out_tid == TID_W'(t)));

    assert_flag_excl_R4: assert property (@(posedge clk) disable iff (rst)
      $onehot0({up_block[t], up_unblock[t]}));
  end

endmodule

bind mtps_stage_ctl mtps_stage_chk #(
  .NTHREADS (NTHREADS),
  .WIDTH    (WIDTH),
  .CNT_W    (CNT_W)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .sq_vld      (sq_vld),
  .sq_tid      (sq_tid),
  .dn_block    (dn_block),
  .res_stall   (res_stall),
  .dn_free     (dn_free),
  .out_vld     (out_vld),
  .out_tid     (out_tid),
  .up_block    (up_block),
  .up_unblock  (up_unblock),
  .thr_status  (thr_status),
  .run_cycles  (run_cycles),
  .idle_cycles (idle_cycles),
  .occ_total   (occ_total)
);

// File: tb/mtps_stage_ctl_bench.sv
module mtps_stage_ctl_bench;

  localparam int NT = 2;
  localparam int W  = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_vld = 1'b0, in_dead = 1'b0, sq_vld = 1'b0;
  logic [0:0]  in_tid = '0, sq_tid = '0, out_tid;
  logic [15:0] in_seq = '0, sq_seq = '0, out_seq;
  logic [1:0]  dn_block = '0, res_stall = '0, up_block, up_unblock;
  logic [2:0]  dn_free = '0;
  logic        out_vld;
  logic [5:0]  thr_status;
  logic [31:0] run_cycles, idle_cycles;

  always #5 clk = ~clk;

  mtps_stage_ctl u_mtps_stage_ctl (
    .clk, .rst, .in_vld, .in_tid, .in_seq, .in_dead,
    .sq_vld, .sq_tid, .sq_seq, .dn_block, .res_stall, .dn_free,
    .out_vld, .out_tid, .out_seq, .up_block, .up_unblock,
    .thr_status, .run_cycles, .idle_cycles
  );

  // Reference model state
  int    mq [NT][$];
  int    m_st [NT];
  bit    m_blk [NT];
  bit    m_unb [NT];
  bit    m_vld;
  int    m_tid, m_seq;
  int    m_run, m_idle;
  int    nseq [NT];
  int    n_chk = 0, n_err = 0;
  string phase = "R1";
  bit    done = 0;

  task automatic model_reset();
    for (int t = 0; t < NT; t++) begin
      mq[t].delete(); m_st[t] = 0; m_blk[t] = 0; m_unb[t] = 0;
    end
    m_vld = 0; m_run = 0; m_idle = 0;
  endtask

  task automatic model_step();
    int  total = mq[0].size() + mq[1].size();
    int  g = -1;
    int  nst [NT];
    bit  take, stall, cut, ins;
    take = in_vld && !in_dead && !(sq_vld && sq_tid == in_tid && in_seq > sq_seq) && total < W;
    for (int t = 0; t < NT; t++) begin
      stall = dn_block[t] || res_stall[t];
      cut   = sq_vld && sq_tid == t;
      if (g < 0 && !stall && !cut && (m_st[t] == 0 || m_st[t] == 1 || m_st[t] == 3)
          && mq[t].size() > 0 && dn_free > 0) g = t;
    end
    for (int t = 0; t < NT; t++) begin
      stall = dn_block[t] || res_stall[t];
      cut   = sq_vld && sq_tid == t;
      ins   = take && in_tid == t;
      m_blk[t] = 0; m_unb[t] = 0; nst[t] = m_st[t];
      if (stall) begin nst[t] = 2; m_blk[t] = (m_st[t] != 2); end
      else if (cut) nst[t] = 4;
      else if (m_st[t] == 2) nst[t] = 3;
      else if (m_st[t] == 4) nst[t] = (mq[t].size() > 0) ? 3 : 1;
      else if (mq[t].size() > 0 && dn_free == 0) nst[t] = 2;
      else if (m_st[t] == 3) begin
        if (mq[t].size() - (g == t ? 1 : 0) == 0 && !ins) begin nst[t] = 1; m_unb[t] = 1; end
      end
      else if (m_st[t] == 0 && ins) nst[t] = 1;
    end
    for (int t = 0; t < NT; t++) begin
      if (sq_vld && sq_tid == t) begin
        int keep [$];
        foreach (mq[t][i]) if (mq[t][i] <= int'(sq_seq)) keep.push_back(mq[t][i]);
        mq[t] = keep;
      end
      m_st[t] = nst[t];
    end
    m_vld = (g >= 0);
    if (g >= 0) begin m_tid = g; m_seq = mq[g].pop_front(); m_run++; end
    else m_idle++;
    if (take) mq[int'(in_tid)].push_back(int'(in_seq));
  endtask

  task automatic chk(string req, string what, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s (phase %s) at %0t: actual=%0d expected=%0d", req, what, phase, $time, act, exp);
    end
  endtask

  task automatic compare();
    chk("R9", "out_vld", out_vld, m_vld);
    if (m_vld && out_vld) begin
      chk("R9", "out_tid", out_tid, m_tid);
      chk("R9", "out_seq", out_seq, m_seq);
    end
    for (int t = 0; t < NT; t++) begin
      chk("R2", "thr_status", thr_status[3*t +: 3], m_st[t]);
      chk("R3", "up_block", up_block[t], m_blk[t]);
      chk("R4", "up_unblock", up_unblock[t], m_unb[t]);
    end
    chk("R11", "run_cycles", run_cycles, m_run);
    chk("R11", "idle_cycles", idle_cycles, m_idle);
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare();
    in_vld = 0; in_dead = 0; sq_vld = 0;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic send(int t);
    nseq[t]++;
    in_vld = 1; in_tid = 1'(t); in_seq = 16'(nseq[t]);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired: actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    nseq[0] = 0; nseq[1] = 100;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk("R1", "out_vld", out_vld, 0);
    chk("R1", "thr_status", thr_status, 0);
    chk("R1", "up_block", up_block, 0);
    chk("R1", "up_unblock", up_unblock, 0);
    chk("R1", "run_cycles", run_cycles, 0);
    chk("R1", "idle_cycles", idle_cycles, 0);
    rst = 0;

    phase = "R2"; dn_free = 2;
    for (int i = 0; i < 3; i++) begin send(0); tick(); end
    ticks(3);

    phase = "R9"; dn_free = 1;
    for (int i = 0; i < 4; i++) begin send(i % 2); tick(); end
    ticks(6);

    phase = "R10"; dn_free = 0;
    send(0); tick(); send(0); tick();
    ticks(3);
    dn_free = 2; ticks(5);

    phase = "R4"; dn_block[1] = 1;
    send(1); tick(); send(1); tick();
    ticks(3);
    dn_block[1] = 0; ticks(6);

    phase = "R3"; res_stall[0] = 1;
    send(0); tick(); tick();
    res_stall[0] = 0; ticks(5);

    phase = "R7"; dn_free = 0;
    for (int i = 0; i < 6; i++) begin send(i % 2); tick(); end
    dn_free = 3; ticks(10);

    phase = "R5 R6"; dn_free = 0;
    for (int i = 0; i < 3; i++) begin send(0); tick(); end
    sq_vld = 1; sq_tid = 0; sq_seq = 16'(nseq[0] - 2);
    send(0); tick();
    ticks(2);
    dn_free = 2; ticks(6);
    dn_free = 0; send(1); tick(); send(1); tick();
    dn_block[1] = 1; sq_vld = 1; sq_tid = 1; sq_seq = 16'(nseq[1] - 1); tick();
    dn_block[1] = 0; dn_free = 2; ticks(6);

    phase = "R8";
    in_vld = 1; in_tid = 1; in_seq = 16'(nseq[1] + 1); in_dead = 1; nseq[1]++; tick();
    ticks(3);

    phase = "mixed R5 R7 R9";
    for (int c = 0; c < 3000; c++) begin
      if ($urandom_range(0, 1) == 1) begin
        send(int'($urandom_range(0, 1)));
        in_dead = ($urandom_range(0, 9) == 0);
      end
      if ($urandom_range(0, 19) == 0) begin
        int st = int'($urandom_range(0, 1));
        int s  = nseq[st] - int'($urandom_range(0, 3));
        sq_vld = 1; sq_tid = 1'(st); sq_seq = 16'((s < 0) ? 0 : s);
      end
      for (int t = 0; t < NT; t++) begin
        if ($urandom_range(0, 9) == 0) dn_block[t] = ~dn_block[t];
        if ($urandom_range(0, 14) == 0) res_stall[t] = ~res_stall[t];
      end
      dn_free = 3'($urandom_range(0, 4));
      tick();
    end
    dn_block = 0; res_stall = 0; dn_free = 4;
    ticks(12);
    done = 1;
    finish_run();
  end

endmodule